// File: doc/BRIEF.md
# Conversion Period Scheduler

This block decides when a temperature sensor's converter runs. It has three operating modes. In continuous mode it launches one measurement per conversion period. In shutdown mode it launches nothing. In one-shot mode it runs a single measurement and then stays idle. When averaging is enabled, a measurement is eight back-to-back conversions whose mean is published. Otherwise a measurement is a single conversion. Every interval is counted in ticks of an external 50 µs timebase.

The block owns three control bits and updates them through write strobes: the mode bit, the self-clearing one-shot bit and the software-reset request. The period code, the conversion-time code and the averaging enable are level inputs taken from a configuration register. Each conversion is a start/done handshake with an external converter. The block publishes each finished measurement as a 16-bit two's complement word, qualified by a one-cycle valid strobe.

Top module: `conv_sched`

## Requirements
- R1: While reset is held, `conv_start_o`, `result_valid_o`, `oneshot_o`, `shutdown_o` and `soft_rst_o` are 0. The mode after reset is continuous, so the first conversion start appears in the first cycle after reset is released.
- R2: In continuous mode, successive measurement launches lie exactly P ticks apart. P is 128 ticks for period code 0 and 625·2^(c−1) ticks for period code c = 1..7, which gives 625, 1250, 2500, 5000, 10000, 20000 and 40000 ticks.
- R3: With averaging enabled, the cycle length is the larger of P and 8·T. T is the conversion time per conversion in ticks: 128, 70, 40 and 24 for conversion-time codes 0, 1, 2 and 3.
- R4: With averaging enabled, a measurement issues 8 starts. Each start after the first follows the done of the previous conversion. The result is the sum of the eight signed samples, arithmetically shifted right by 3 (floor of the mean).
- R5: With averaging disabled, a measurement issues one start, and the published result equals the returned sample.
- R6: A mode write with data 1 selects shutdown and data 0 selects continuous. In shutdown no new measurement is launched, but a measurement already in progress completes and its result is published.
- R7: A one-shot write sets `oneshot_o` and `shutdown_o` in the next cycle. It runs exactly one measurement. `oneshot_o` returns to 0 in the same cycle in which that measurement's `result_valid_o` is 1. No launch follows.
- R8: A one-shot measurement also uses eight averaged conversions when averaging is enabled.
- R9: A software-reset write raises `soft_rst_o` from the next cycle for exactly 20 ticks. During that pulse, no start is issued and mode and one-shot writes are ignored. At its end the block is in continuous mode with the one-shot bit clear, and it launches at once.
- R10: `conv_start_o` and `result_valid_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timebase tick every 50 µs |
| period_code_i | input | 3 | Conversion period code |
| ctime_code_i | input | 2 | Per-conversion time code |
| avg_en_i | input | 1 | 1 = average eight conversions per measurement |
| mode_wr_i | input | 1 | Write strobe for the mode bit |
| mode_wdata_i | input | 1 | Mode value: 1 shutdown, 0 continuous |
| oneshot_wr_i | input | 1 | Write strobe that requests one measurement |
| srst_wr_i | input | 1 | Write strobe that requests a software reset |
| conv_done_i | input | 1 | Converter finished; sample valid this cycle |
| conv_data_i | input | 16 | Signed converter sample |
| conv_start_o | output | 1 | One-cycle request to start a conversion |
| result_o | output | 16 | Last published measurement, two's complement |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| oneshot_o | output | 1 | One-shot bit, self-clearing |
| shutdown_o | output | 1 | Mode bit: 1 = shutdown |
| soft_rst_o | output | 1 | Internal reset pulse |

## Verification
The assertions check on every cycle that the start and valid strobes last one cycle each. They also check that a one-shot write forces shutdown and sets the one-shot bit, and that this bit only falls together with a published result or at the end of a software reset. Further cycle-by-cycle checks cover three points: an idle block in shutdown with no pending one-shot never starts a conversion, a reset pulse begins only after a request, and the block leaves that pulse in continuous mode. Some behaviours need whole scenarios and are shown only by the bench. These are the exact spacing of launches for each period code and under the averaging stretch, the floor-of-mean arithmetic for negative samples, a mid-measurement switch to shutdown that still publishes its result, and the exact 20-tick length of the reset pulse.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2,
        ST_SRST  = 2'd3
    } sched_state_e;

endpackage

// File: rtl/conv_cycle_len.sv
module conv_cycle_len #(
    parameter int CNT_W              = 17,
    parameter int SHORT_PERIOD_TICKS = 128,
    parameter int BASE_PERIOD_TICKS  = 625,
    parameter int CT_TICKS_0         = 128,
    parameter int CT_TICKS_1         = 70,
    parameter int CT_TICKS_2         = 40,
    parameter int CT_TICKS_3         = 24,
    parameter int AVG_COUNT          = 8
) (
    input  logic [2:0]       period_code_i,
    input  logic [1:0]       ctime_code_i,
    input  logic             avg_en_i,
    output logic [CNT_W-1:0] cycle_ticks_o
);

    logic [CNT_W-1:0] period_ticks;
    logic [CNT_W-1:0] conv_ticks;
    logic [CNT_W-1:0] meas_ticks;

    always_comb begin
        // code 0 is the short period, codes 1..7 double from the base
        if (period_code_i == 3'd0) begin
            period_ticks = CNT_W'(SHORT_PERIOD_TICKS);
        end else begin
            period_ticks = CNT_W'(BASE_PERIOD_TICKS) << (period_code_i - 3'd1);
        end

        unique case (ctime_code_i)
            2'd0:    conv_ticks = CNT_W'(CT_TICKS_0);
            2'd1:    conv_ticks = CNT_W'(CT_TICKS_1);
            2'd2:    conv_ticks = CNT_W'(CT_TICKS_2);
            default: conv_ticks = CNT_W'(CT_TICKS_3);
        endcase

        meas_ticks    = avg_en_i ? conv_ticks * CNT_W'(AVG_COUNT) : conv_ticks;
        // the cycle stretches when the measurement does not fit the period
        cycle_ticks_o = (meas_ticks > period_ticks) ? meas_ticks : period_ticks;
    end

endmodule

// File: rtl/conv_accum.sv
module conv_accum #(
    parameter int DATA_W    = 16,
    parameter int AVG_SHIFT = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              add_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] mean_o
);

    localparam int SUM_W = DATA_W + AVG_SHIFT;

    logic signed [SUM_W-1:0] acc_d, acc_q;
    logic signed [SUM_W-1:0] sample_ext;
    logic signed [SUM_W-1:0] shifted;

    always_comb begin
        sample_ext = {{AVG_SHIFT{data_i[DATA_W-1]}}, data_i};
        acc_d      = (clear_i ? '0 : acc_q) + (add_i ? sample_ext : '0);
        // mean includes the sample being added this cycle
        shifted    = acc_d >>> AVG_SHIFT;
        mean_o     = shifted[DATA_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R4: a fresh measurement starts from an empty sum
    assert_acc_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clear_i && !add_i) |=> (acc_q == '0));

endmodule

// File: rtl/conv_sched.sv
module conv_sched
    import conv_sched_pkg::*;
#(
    parameter int DATA_W             = 16,
    parameter int CNT_W              = 17,
    parameter int SHORT_PERIOD_TICKS = 128,
    parameter int BASE_PERIOD_TICKS  = 625,
    parameter int CT_TICKS_0         = 128,
    parameter int CT_TICKS_1         = 70,
    parameter int CT_TICKS_2         = 40,
    parameter int CT_TICKS_3         = 24,
    parameter int AVG_COUNT          = 8,
    parameter int SRST_TICKS         = 20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [2:0]        period_code_i,
    input  logic [1:0]        ctime_code_i,
    input  logic              avg_en_i,
    input  logic              mode_wr_i,
    input  logic              mode_wdata_i,
    input  logic              oneshot_wr_i,
    input  logic              srst_wr_i,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic              conv_start_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_valid_o,
    output logic              oneshot_o,
    output logic              shutdown_o,
    output logic              soft_rst_o
);

    localparam int AVG_SHIFT = $clog2(AVG_COUNT);
    localparam int SIDX_W    = (AVG_SHIFT > 0) ? AVG_SHIFT : 1;
    localparam int RCNT_W    = $clog2(SRST_TICKS + 1);

    typedef struct packed {
        sched_state_e      st;
        logic [CNT_W-1:0]  per_cnt;
        logic              due;
        logic [SIDX_W-1:0] sidx;
        logic              avg_meas;
        logic              os_meas;
        logic              shut;
        logic              os;
        logic [RCNT_W-1:0] rcnt;
        logic [DATA_W-1:0] res;
        logic              vld;
    } sched_s;

    localparam sched_s RESET_S = '{
        st:       ST_IDLE,
        per_cnt:  '0,
        due:      1'b1,
        sidx:     '0,
        avg_meas: 1'b0,
        os_meas:  1'b0,
        shut:     1'b0,
        os:       1'b0,
        rcnt:     '0,
        res:      '0,
        vld:      1'b0
    };

    sched_s           sched_d, sched_q;
    logic [CNT_W-1:0] cycle_ticks;
    logic [DATA_W-1:0] mean;
    logic             acc_clear, acc_add;
    logic             timer_hit, last_sample;

    conv_cycle_len #(
        .CNT_W              (CNT_W),
        .SHORT_PERIOD_TICKS (SHORT_PERIOD_TICKS),
        .BASE_PERIOD_TICKS  (BASE_PERIOD_TICKS),
        .CT_TICKS_0         (CT_TICKS_0),
        .CT_TICKS_1         (CT_TICKS_1),
        .CT_TICKS_2         (CT_TICKS_2),
        .CT_TICKS_3         (CT_TICKS_3),
        .AVG_COUNT          (AVG_COUNT)
    ) u_cycle_len (
        .period_code_i (period_code_i),
        .ctime_code_i  (ctime_code_i),
        .avg_en_i      (avg_en_i),
        .cycle_ticks_o (cycle_ticks)
    );

    conv_accum #(
        .DATA_W    (DATA_W),
        .AVG_SHIFT (AVG_SHIFT)
    ) u_accum (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (acc_clear),
        .add_i   (acc_add),
        .data_i  (conv_data_i),
        .mean_o  (mean)
    );

    always_comb begin
        sched_d     = sched_q;
        sched_d.vld = 1'b0;
        acc_clear   = 1'b0;
        acc_add     = 1'b0;
        timer_hit   = tick_i && !sched_q.due &&
                      (sched_q.per_cnt >= cycle_ticks - CNT_W'(1));
        last_sample = sched_q.avg_meas ? (sched_q.sidx == SIDX_W'(AVG_COUNT - 1)) : 1'b1;

        // period timer counts ticks from the last launch, then latches due
        if (timer_hit) begin
            sched_d.due = 1'b1;
        end else if (tick_i && !sched_q.due) begin
            sched_d.per_cnt = sched_q.per_cnt + CNT_W'(1);
        end

        unique case (sched_q.st)
            ST_IDLE: begin
                if (sched_q.os || (!sched_q.shut && (sched_q.due || timer_hit))) begin
                    sched_d.st       = ST_START;
                    sched_d.sidx     = '0;
                    sched_d.avg_meas = avg_en_i;
                    sched_d.os_meas  = sched_q.os;
                    sched_d.due      = 1'b0;
                    sched_d.per_cnt  = '0;
                    acc_clear        = 1'b1;
                end
            end
            ST_START: begin
                sched_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done_i) begin
                    acc_add = 1'b1;
                    if (last_sample) begin
                        sched_d.st  = ST_IDLE;
                        sched_d.res = sched_q.avg_meas ? mean : conv_data_i;
                        sched_d.vld = 1'b1;
                        if (sched_q.os_meas) begin
                            sched_d.os = 1'b0;
                        end
                    end else begin
                        sched_d.sidx = sched_q.sidx + SIDX_W'(1);
                        sched_d.st   = ST_START;
                    end
                end
            end
            default: begin
                if (tick_i) begin
                    if (sched_q.rcnt == RCNT_W'(SRST_TICKS - 1)) begin
                        sched_d = RESET_S;
                    end else begin
                        sched_d.rcnt = sched_q.rcnt + RCNT_W'(1);
                    end
                end
            end
        endcase

        // control writes; all ignored while the reset pulse runs
        if (sched_q.st != ST_SRST) begin
            if (mode_wr_i) begin
                sched_d.shut = mode_wdata_i;
            end
            if (oneshot_wr_i) begin
                sched_d.os   = 1'b1;
                sched_d.shut = 1'b1;
            end
            if (srst_wr_i) begin
                sched_d.st   = ST_SRST;
                sched_d.rcnt = '0;
                sched_d.vld  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sched_q <= RESET_S;
        end else begin
            sched_q <= sched_d;
        end
    end

    assign conv_start_o   = (sched_q.st == ST_START);
    assign soft_rst_o     = (sched_q.st == ST_SRST);
    assign result_o       = sched_q.res;
    assign result_valid_o = sched_q.vld;
    assign oneshot_o      = sched_q.os;
    assign shutdown_o     = sched_q.shut;

    assert_start_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        conv_start_o |=> !conv_start_o);

    assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_valid_o |=> !result_valid_o);

    assert_shut_no_launch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sched_q.st == ST_IDLE && shutdown_o && !oneshot_o) |=> !conv_start_o);

    assert_os_forces_shut_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oneshot_wr_i && !srst_wr_i && !soft_rst_o) |=> (oneshot_o && shutdown_o));

    assert_os_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(oneshot_o) |-> (result_valid_o || $past(soft_rst_o)));

    assert_srst_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(soft_rst_o) |-> $past(srst_wr_i));

    assert_srst_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(soft_rst_o) |-> (!shutdown_o && !oneshot_o));

endmodule

// File: tb/conv_sched_bench.sv
module conv_sched_bench;

    localparam int CONV_LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        tick_half = 1'b0;
    logic [2:0]  period_code = 3'd1;
    logic [1:0]  ctime_code = 2'd0;
    logic        avg_en = 1'b0;
    logic        mode_wr = 1'b0, mode_wdata = 1'b0;
    logic        oneshot_wr = 1'b0, srst_wr = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic        conv_start, result_valid, oneshot, shutdown, soft_rst;
    logic [15:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int n_res    = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    logic [15:0] sample_q[$];
    logic [15:0] exp_q[$];
    string       tag_q[$];
    int          st_q[$];

    conv_sched u_conv_sched (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .tick_i         (tick),
        .period_code_i  (period_code),
        .ctime_code_i   (ctime_code),
        .avg_en_i       (avg_en),
        .mode_wr_i      (mode_wr),
        .mode_wdata_i   (mode_wdata),
        .oneshot_wr_i   (oneshot_wr),
        .srst_wr_i      (srst_wr),
        .conv_done_i    (conv_done),
        .conv_data_i    (conv_data),
        .conv_start_o   (conv_start),
        .result_o       (result),
        .result_valid_o (result_valid),
        .oneshot_o      (oneshot),
        .shutdown_o     (shutdown),
        .soft_rst_o     (soft_rst)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) tick <= tick_half ? ~tick : 1'b1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // converter model: done CONV_LAT+1 negedges after a start
    int cv_cnt = 0;
    bit cv_busy = 1'b0;
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (cv_busy) begin
            if (cv_cnt == 0) begin
                conv_done = 1'b1;
                conv_data = (sample_q.size() > 0) ? sample_q.pop_front() : 16'h0000;
                cv_busy   = 1'b0;
            end else begin
                cv_cnt--;
            end
        end
        if (conv_start) begin
            cv_busy = 1'b1;
            cv_cnt  = CONV_LAT;
            st_q.push_back(cyc);
        end
    end

    // scoreboard monitor
    bit prev_vld = 1'b0;
    always @(negedge clk) begin
        if (rst_n && result_valid) begin
            n_res++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected result", result, 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(result == e, t, result, e);
            end
            check(!prev_vld, "R10 valid width", 1, 0);
        end
        prev_vld = result_valid;
    end

    task automatic push_meas(input logic [15:0] s[], input logic [15:0] e, input string t);
        foreach (s[i]) sample_q.push_back(s[i]);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wait_results(input int k);
        int target;
        target = n_res + k;
        while (n_res < target) @(negedge clk);
    endtask

    task automatic write_mode(input logic v);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic write_oneshot();
        @(negedge clk);
        oneshot_wr = 1'b1;
        @(negedge clk);
        oneshot_wr = 1'b0;
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        int c0, k, base;

        // R1: reset state
        push_meas('{16'h0123}, 16'h0123, "R5 single 0123");
        push_meas('{16'hFF00}, 16'hFF00, "R5 single FF00");
        push_meas('{16'h7FFF}, 16'h7FFF, "R5 single 7FFF");
        repeat (4) @(negedge clk);
        check(!conv_start && !result_valid, "R1 strobes in reset", {conv_start, result_valid}, 0);
        check(!oneshot && !shutdown && !soft_rst, "R1 bits in reset", {oneshot, shutdown, soft_rst}, 0);
        c0 = cyc;
        rst_n = 1'b1;
        wait_results(3);
        write_mode(1'b1);
        check(st_q.size() == 3 && st_q[0] == c0 + 1, "R1 first start", st_q[0], c0 + 1);
        check(st_q[1] - st_q[0] == 625, "R2 gap code 1", st_q[1] - st_q[0], 625);
        check(st_q[2] - st_q[1] == 625, "R2 gap code 1 again", st_q[2] - st_q[1], 625);
        repeat (1500) @(negedge clk);
        check(st_q.size() == 3, "R6 no starts in shutdown", st_q.size(), 3);
        check(shutdown == 1'b1, "R6 mode bit", shutdown, 1);

        // R2: tick every other cycle, code 0 = 128 ticks = 256 cycles
        st_q.delete();
        period_code = 3'd0;
        tick_half   = 1'b1;
        push_meas('{16'h0010}, 16'h0010, "R5 single 0010");
        push_meas('{16'h0020}, 16'h0020, "R5 single 0020");
        push_meas('{16'h0030}, 16'h0030, "R5 single 0030");
        write_mode(1'b0);
        wait_results(3);
        write_mode(1'b1);
        tick_half = 1'b0;
        check(st_q[2] - st_q[1] == 256, "R2 gap in ticks", st_q[2] - st_q[1], 256);

        // R3/R4: averaging stretch and mean
        repeat (300) @(negedge clk);
        st_q.delete();
        avg_en = 1'b1;
        push_meas('{16'd100, 16'd200, 16'd300, 16'd400, 16'd500, 16'd600, 16'd700, 16'd800},
                  16'd450, "R4 mean positive");
        push_meas('{16'hFFFD, 16'hFFFD, 16'hFFFD, 16'hFFFD, 16'hFFFD, 16'hFFFD, 16'hFFFD, 16'hFFFE},
                  16'hFFFD, "R4 floor negative");
        write_mode(1'b0);
        wait_results(2);
        check(st_q.size() == 16, "R4 eight starts each", st_q.size(), 16);
        check(st_q[8] - st_q[0] == 1024, "R3 stretch ct0", st_q[8] - st_q[0], 1024);
        ctime_code = 2'd3;
        push_meas('{16'h0400, 16'h0400, 16'h0400, 16'h0400, 16'h0400, 16'h0400, 16'h0400, 16'h0400},
                  16'h0400, "R4 mean flat");
        push_meas('{16'd7, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
                  16'h0000, "R4 truncation");
        wait_results(2);
        check(st_q[24] - st_q[16] == 192, "R3 stretch ct3", st_q[24] - st_q[16], 192);

        // R6: shutdown in the middle of a measurement
        push_meas('{16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000},
                  16'h8000, "R6 in-flight result");
        while (st_q.size() < 33) @(negedge clk);
        write_mode(1'b1);
        wait_results(1);
        repeat (1000) @(negedge clk);
        check(st_q.size() == 40, "R6 finish then stop", st_q.size(), 40);

        // R7/R8: one-shot with averaging from shutdown
        st_q.delete();
        push_meas('{16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8}, 16'd4, "R8 one-shot mean");
        write_oneshot();
        check(oneshot && shutdown, "R7 bits set", {oneshot, shutdown}, 3);
        wait_results(1);
        check(!oneshot, "R7 self clear", oneshot, 0);
        repeat (1000) @(negedge clk);
        check(st_q.size() == 8, "R8 eight starts, R7 no relaunch", st_q.size(), 8);

        // R7: one-shot from continuous forces shutdown
        st_q.delete();
        avg_en = 1'b0;
        period_code = 3'd7;
        push_meas('{16'h0AAA}, 16'h0AAA, "R5 continuous 0AAA");
        write_mode(1'b0);
        wait_results(1);
        check(!shutdown, "R6 continuous selected", shutdown, 0);
        push_meas('{16'h0BBB}, 16'h0BBB, "R7 one-shot result");
        write_oneshot();
        check(shutdown && oneshot, "R7 forces shutdown", {oneshot, shutdown}, 3);
        wait_results(1);
        repeat (500) @(negedge clk);
        check(st_q.size() == 2, "R7 single launch", st_q.size(), 2);

        // R9: software reset pulse
        base = st_q.size();
        push_meas('{16'h0CCC}, 16'h0CCC, "R9 launch after reset");
        @(negedge clk);
        srst_wr = 1'b1;
        @(negedge clk);
        srst_wr = 1'b0;
        k = 0;
        while (soft_rst && k < 100) begin
            k++;
            if (k == 5) begin
                oneshot_wr = 1'b1; mode_wr = 1'b1; mode_wdata = 1'b1;
            end else begin
                oneshot_wr = 1'b0; mode_wr = 1'b0;
            end
            @(negedge clk);
        end
        oneshot_wr = 1'b0; mode_wr = 1'b0;
        check(k == 20, "R9 pulse length", k, 20);
        check(st_q.size() == base, "R9 no start in pulse", st_q.size(), base);
        check(!shutdown && !oneshot, "R9 writes ignored, defaults", {oneshot, shutdown}, 0);
        wait_results(1);
        write_mode(1'b1);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
        finish_sim();
    end

endmodule